// File: doc/BRIEF.md
# MDIO Management Master with Table-Driven Clock Divider

This block drives the two-wire PHY management bus. It produces the management clock (MDC) and runs clause-22 read and write frames on the serial data line (MDIO). MDC is made by dividing the bus clock alone, which is the only clock the block uses. The divisor comes from a fixed table that a 3-bit select code indexes. A small configuration register holds the select code and a preamble-skip flag. A read or write request is accepted with a one-cycle `start` pulse. The request names the PHY address, the register address and, for a write, 16 data bits. The block then reports `busy` until the last bit period has ended.

Each frame has these parts, sent in this order. First, an optional preamble of 32 ones. Then the start pattern `01`, the opcode (`01` write, `10` read), five PHY address bits, five register address bits, two turnaround bits and sixteen data bits. Every field is sent MSB first. On a read the master lets go of MDIO for the turnaround and data bits. It shifts in the PHY's answer during the high phase of MDC and presents the 16-bit result on `rd_data` once the frame ends. Software has to choose a select code that keeps MDC within what the attached PHY accepts. The usual limit is 2.5 MHz, and some PHYs accept up to 12.5 MHz.

The controller has five states. IDLE waits for a request. PREAMBLE sends 32 one-bits. HEADER sends start, opcode and both addresses (14 bits). TURNAROUND covers 2 bits. DATA covers 16 bits. The transitions are:

- IDLE to PREAMBLE, on `start` with preamble skip clear.
- IDLE to HEADER, on `start` with preamble skip set.
- PREAMBLE to HEADER, at the end of the 32nd bit.
- HEADER to TURNAROUND, at the end of the 14th bit.
- TURNAROUND to DATA, at the end of the 2nd bit.
- DATA to IDLE, at the end of the 16th bit.

Top module: `mdio_master`

## Requirements
- R1: The divisor D (bus-clock cycles per MDC period) follows the select code: 0→4, 1→4, 2→6, 3→8, 4→10, 5→20, 6→30, 7→40.
- R2: After reset the select code is 0, preamble skip is clear, `busy`, `mdc`, `mdio_oe` and `mdio_o` are low, and `rd_data` is zero. While idle, `mdc` and `mdio_oe` stay low.
- R3: Within each bit period of D bus cycles, `mdc` is low for the first D/2 cycles (rounded down) and high for the rest. Bit periods follow one another with no gap.
- R4: With preamble skip clear, a frame opens with 32 bit periods in which `mdio_oe`=1 and `mdio_o`=1. With preamble skip set, a frame begins directly at the start pattern.
- R5: After the preamble, the master drives `01`, then the opcode (`01` write, `10` read), then PHY address[4:0] and register address[4:0], MSB first. On a write it then drives turnaround `10` and wr_data[15:0], MSB first. `mdio_o` changes only at the beginning of a bit period.
- R6: On a read, `mdio_oe` is low through the 2 turnaround and 16 data bit periods. `mdio_i` is sampled in the first bus cycle of each data bit's MDC high phase. `rd_data` takes the 16 sampled bits, first bit as MSB, at the end of the frame. `rd_data` is unchanged by write frames.
- R7: `busy` rises on the cycle after a `start` is accepted while idle. It stays high for exactly (64 or 32)·D cycles. A `start` that arrives while `busy` is high is ignored.
- R8: The configuration word `cfg_wdata` carries the select code in bits [4:2] and preamble skip in bit 1. Bit 0 has no effect. The select code and the skip flag are taken when a frame starts, so a configuration write during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, the only divider input |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 5 | [4:2] clock select, [1] preamble skip, [0] unused |
| start | input | 1 | Request pulse for one frame |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write frame |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Level driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Last read result |

## Verification
The bench steps through every select code, so a wrong table entry, or a code 1 that did not alias code 0, would stretch or shrink both the MDC waveform and the measured `busy` length. Frames are run with and without preamble. A design that ignored the skip flag, or that skipped 31 or 33 bits, would shift every later field and fail on the driven bits. Several tests poke at the frame while it runs: a configuration rewrite and a second `start` arrive mid-frame, and a write follows a read. A block that re-read the configuration on the fly, restarted on a new request, or cleared `rd_data` on a write would show up at once. Read responses put alternating and edge bit patterns on `mdio_i`, which catches sampling one cycle early or late and reversed bit order.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int SEL_W    = 3;
    localparam int DIV_W    = 6;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 4 + 2 * ADDR_W;
    localparam int TA_BITS  = 2;
    localparam int SH_W     = HDR_BITS + TA_BITS + DATA_W;
    localparam int BCNT_W   = $clog2(PRE_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    function automatic logic [DIV_W-1:0] sel_to_div(input logic [SEL_W-1:0] sel);
        logic [DIV_W-1:0] d;
        unique case (sel)
            3'd0, 3'd1: d = DIV_W'(4);
            3'd2:       d = DIV_W'(6);
            3'd3:       d = DIV_W'(8);
            3'd4:       d = DIV_W'(10);
            3'd5:       d = DIV_W'(20);
            3'd6:       d = DIV_W'(30);
            3'd7:       d = DIV_W'(40);
        endcase
        return d;
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          mdc,
    output logic          sample,
    output logic          bit_end
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] half;
    logic [DW-1:0] last;

    assign half = div >> 1;
    assign last = div - DW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == last) cnt <= '0;
        else                  cnt <= cnt + DW'(1);
    end

    // low phase gets floor(D/2) cycles, high phase the remainder
    assign mdc     = run && (cnt >= half);
    assign sample  = run && (cnt == half);
    assign bit_end = run && (cnt == last);

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_nopre,
    input  logic              mdio_i,
    input  logic              sample,
    input  logic              bit_end,
    output logic              busy,
    output logic [DIV_W-1:0]  div_q,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    mdio_state_e       state, nxt;
    logic [BCNT_W-1:0] bcnt, lim;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] rdsh;
    logic              rd_q;
    logic              accept;
    logic              seg_done;

    // next-state logic
    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        lim      = '0;
        unique case (state)
            ST_IDLE: lim = '0;
            ST_PRE:  lim = BCNT_W'(PRE_BITS - 1);
            ST_HDR:  lim = BCNT_W'(HDR_BITS - 1);
            ST_TA:   lim = BCNT_W'(TA_BITS - 1);
            ST_DATA: lim = BCNT_W'(DATA_W - 1);
        endcase
        seg_done = bit_end && (bcnt == lim);
        unique case (state)
            ST_IDLE: if (start) begin
                accept = 1'b1;
                nxt    = cfg_nopre ? ST_HDR : ST_PRE;
            end
            ST_PRE:  if (seg_done) nxt = ST_HDR;
            ST_HDR:  if (seg_done) nxt = ST_TA;
            ST_TA:   if (seg_done) nxt = ST_DATA;
            ST_DATA: if (seg_done) nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= '0;
            sh      <= '0;
            rdsh    <= '0;
            rd_q    <= 1'b0;
            div_q   <= sel_to_div('0);
            rd_data <= '0;
        end else begin
            if (state != nxt)  bcnt <= '0;
            else if (bit_end)  bcnt <= bcnt + BCNT_W'(1);

            if (accept) begin
                rd_q  <= rd_nwr;
                div_q <= sel_to_div(cfg_sel);
                sh    <= {2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr,
                          (rd_nwr ? 2'b00 : 2'b10), (rd_nwr ? '0 : wr_data)};
            end else if (bit_end && state != ST_PRE && state != ST_IDLE) begin
                sh <= {sh[SH_W-2:0], 1'b0};
            end

            if (sample && state == ST_DATA && rd_q)
                rdsh <= {rdsh[DATA_W-2:0], mdio_i};

            if (state == ST_DATA && nxt == ST_IDLE && rd_q)
                rd_data <= rdsh;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRE:  begin mdio_oe = 1'b1; mdio_o = 1'b1; end
            ST_HDR:  begin mdio_oe = 1'b1; mdio_o = sh[SH_W-1]; end
            ST_TA, ST_DATA: begin
                mdio_oe = !rd_q;
                mdio_o  = !rd_q && sh[SH_W-1];
            end
        endcase
    end

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_div_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));
    p_div_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (div_q inside {6'd4, 6'd6, 6'd8, 6'd10, 6'd20, 6'd30, 6'd40}));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [SEL_W+1:0]    cfg_wdata,
    input  logic                start,
    input  logic                rd_nwr,
    input  logic [ADDR_W-1:0]   phy_addr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                mdio_i,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    output logic                busy,
    output logic [DATA_W-1:0]   rd_data
);
    logic [SEL_W-1:0] cfg_sel_q;
    logic             cfg_nopre_q;
    logic             cfg_unused_bit;
    logic [DIV_W-1:0] div_q;
    logic             sample, bit_end;

    assign cfg_unused_bit = cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_sel_q   <= '0;
            cfg_nopre_q <= 1'b0;
        end else if (cfg_wr) begin
            cfg_sel_q   <= cfg_wdata[SEL_W+1:2];
            cfg_nopre_q <= cfg_wdata[1];
        end
    end

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_nwr    (rd_nwr),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .cfg_sel   (cfg_sel_q),
        .cfg_nopre (cfg_nopre_q),
        .mdio_i    (mdio_i),
        .sample    (sample),
        .bit_end   (bit_end),
        .busy      (busy),
        .div_q     (div_q),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data)
    );

    mdio_mdc_gen #(.DW(DIV_W)) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .div     (div_q),
        .mdc     (mdc),
        .sample  (sample),
        .bit_end (bit_end)
    );

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
    p_mdio_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc) |-> $stable(mdio_o));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, busy;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .start(start), .rd_nwr(rd_nwr), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference ----------------
    function automatic int div_of(input int sel);
        int t[8] = '{4, 4, 6, 8, 10, 20, 30, 40};
        return t[sel];
    endfunction

    int          m_sel, m_cyc, m_div, m_len;
    bit          m_pre_skip, m_busy, m_nopre, m_rd;
    logic [31:0] m_frame;
    logic [15:0] m_rdv, m_resp, resp_next;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_pre_skip = 0; m_busy = 0; m_cyc = 0; m_rdv = '0;
            m_div = 4; m_len = 64; m_nopre = 0; m_rd = 0; m_frame = '0; m_resp = '0;
        end else begin
            if (m_busy) begin
                m_cyc++;
                if (m_cyc == m_len * m_div) begin
                    m_busy = 0;
                    if (m_rd) m_rdv = m_resp;
                end
            end else if (start) begin
                m_busy  = 1;
                m_cyc   = 0;
                m_div   = div_of(m_sel);
                m_nopre = m_pre_skip;
                m_len   = m_pre_skip ? 32 : 64;
                m_rd    = rd_nwr;
                m_resp  = resp_next;
                m_frame = {2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr,
                           (rd_nwr ? 2'b00 : 2'b10), (rd_nwr ? 16'h0 : wr_data)};
            end
            if (cfg_wr) begin
                m_sel      = int'(cfg_wdata[4:2]);
                m_pre_skip = cfg_wdata[1];
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison and PHY responder, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_mdc, e_oe, e_o;
            int f;
            e_mdc = 0; e_oe = 0; e_o = 0; f = 0;
            if (m_busy) begin
                f     = m_cyc / m_div + (m_nopre ? 32 : 0);
                e_mdc = (m_cyc % m_div) >= (m_div / 2);
                if (f < 32) begin
                    e_oe = 1; e_o = 1;
                end else if (f < 46 || !m_rd) begin
                    e_oe = 1; e_o = m_frame[31 - (f - 32)];
                end
            end
            chk({15'd0, busy},    {15'd0, m_busy}, "R7 busy");
            chk({15'd0, mdc},     {15'd0, e_mdc},  "R1/R3 mdc");
            chk({15'd0, mdio_oe}, {15'd0, e_oe},   "R6 mdio_oe");
            chk({15'd0, mdio_o},  {15'd0, e_o},    "R4/R5 mdio_o");
            chk(rd_data,          m_rdv,           "R6 rd_data");
            mdio_i <= (m_busy && m_rd && f >= 48) ? m_resp[15 - (f - 48)] : 1'b1;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg(input int sel, input bit skip, input bit b0);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = {sel[2:0], skip, b0};
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rsp, input int exp_len);
        int n;
        while (busy) @(negedge clk);
        @(negedge clk);
        start = 1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; resp_next = rsp;
        @(negedge clk);
        start = 0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(16'(n), 16'(exp_len), "R1 busy length");
    endtask

    initial begin
        resp_next = '0;
        repeat (3) @(negedge clk);
        chk({11'd0, busy, mdc, mdio_oe, mdio_o, 1'b0}, 16'h0, "R2 reset outputs");
        chk(rd_data, 16'h0, "R2 reset rd_data");
        rst_n = 1;
        @(negedge clk);
        // R2: default select 0 (D=4) with preamble
        frame(0, 5'h01, 5'h1F, 16'hA5C3, 16'h0, 64 * 4);
        // R6: read, D=6, no preamble
        cfg(2, 1, 0);
        frame(1, 5'h1F, 5'h00, 16'hFFFF, 16'h8001, 32 * 6);
        chk(rd_data, 16'h8001, "R6 read result");
        // R8: bit 0 set has no effect; select 1 aliases 4
        cfg(1, 0, 1);
        frame(0, 5'h0A, 5'h15, 16'h0001, 16'h0, 64 * 4);
        chk(rd_data, 16'h8001, "R6 rd_data kept over write");
        cfg(3, 0, 0);
        frame(1, 5'h15, 5'h0A, 16'h0, 16'h5AA5, 64 * 8);
        chk(rd_data, 16'h5AA5, "R6 read result D=8");
        // R7/R8: mid-frame start and config change
        cfg(4, 1, 0);
        fork
            frame(0, 5'h11, 5'h02, 16'h1234, 16'h0, 32 * 10);
            begin
                repeat (40) @(negedge clk);
                start = 1; rd_nwr = 1; phy_addr = 5'h1E; wr_data = 16'hFFFF;
                @(negedge clk);
                start = 0;
                cfg_wr = 1; cfg_wdata = {3'd7, 1'b0, 1'b0};
                @(negedge clk);
                cfg_wr = 0;
            end
        join
        frame(1, 5'h03, 5'h04, 16'h0, 16'hFFFE, 64 * 40);
        chk(rd_data, 16'hFFFE, "R6 read result D=40");
        cfg(5, 0, 0);
        frame(0, 5'h00, 5'h00, 16'hFFFF, 16'h0, 64 * 20);
        cfg(6, 1, 0);
        frame(1, 5'h1C, 5'h13, 16'h0, 16'h3C0F, 32 * 30);
        chk(rd_data, 16'h3C0F, "R6 read result D=30");
        cfg(0, 0, 0);
        frame(1, 5'h07, 5'h08, 16'h0, 16'h0000, 64 * 4);
        chk(rd_data, 16'h0000, "R6 read zeros");
        repeat (5) @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule